// File: doc/BRIEF.md
# Parallel Bus Strobe Timing Monitor

This block watches the active-low chip-select, read and write strobes of an asynchronous parallel peripheral bus. It samples them with a fast reference clock and times every access against three minimum intervals. The first is chip-select assertion to read assertion. The second is the width of the write-low pulse. The third is write release to chip-select release. An access that breaks a rule would not be latched by the peripheral. A write that breaks a rule is therefore counted as lost, since in the system it shows up as a register that never took the new value, for example a clock that does not advance.

All three strobes pass through one synchronizer of equal depth. Relative intervals between their edges are therefore kept exactly, and each interval is counted in whole reference cycles. Each rule has its own sticky flag, a one-cycle event pulse and a saturating counter. Completed writes are sorted into a good counter and a lost counter. A synchronous clear input resets every flag and counter. The limits are parameters given in reference cycles: 6, 4 and 4 at a 100 MHz reference.

Top module: `strobe_timing_monitor`

## Requirements
- R1: Each strobe is sampled through SYNC_STAGES (default 2) flops. A strobe change applied before rising edge k shows its effect on the outputs just after rising edge k+SYNC_STAGES. While rst_n is low, all flags, event pulses, outcome pulses and counters are zero.
- R2: If the read strobe falls while chip-select is low, fewer than RD_SETUP_CYC cycles after chip-select fell, that is a read setup violation. A same-cycle fall counts as 0 cycles. The violation pulses viol_event bit 0, sets viol_flag bit 0 and increments rd_setup_cnt. An interval of exactly RD_SETUP_CYC passes.
- R3: A write pulse is opened by a write fall while chip-select is low. If it closes with a write rise fewer than WR_WIDTH_CYC cycles after it opened, that is a width violation. The violation uses viol_event bit 2, viol_flag bit 2 and wr_width_cnt, and the write is lost. A pulse of exactly WR_WIDTH_CYC passes.
- R4: If chip-select rises fewer than WR_HOLD_CYC cycles after the last write rise of the frame, that is a hold violation. A rise in the same cycle counts as 0 cycles. The violation uses viol_event bit 1, viol_flag bit 1 and wr_hold_cnt, and the write is lost.
- R5: If chip-select rises while a write pulse is still open, that is a hold violation and the write is lost. No width check is made for that write, and its later write rise is ignored.
- R6: Read and write edges that occur while chip-select is high change no flag, counter or pulse.
- R7: A closed write is judged when chip-select rises, or earlier when a new write opens in the same frame; in that case no hold rule applies to the earlier write. When judged, the write pulses either wr_good_pulse or wr_lost_pulse, never both, and the matching counter increments.
- R8: Each flag stays set until clr is sampled high. clr zeroes all flags and all five counters on the next edge, and it wins over a violation or outcome in the same cycle. clr does not suppress the event or outcome pulses.
- R9: Every counter is CNT_W bits wide and holds at 2**CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sampling clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released in step with clk |
| clr | input | 1 | Synchronous clear of flags and counters |
| cs_n_in | input | 1 | Bus chip-select, active low, asynchronous |
| rd_n_in | input | 1 | Bus read strobe, active low, asynchronous |
| wr_n_in | input | 1 | Bus write strobe, active low, asynchronous |
| viol_flag | output | 3 | Sticky violation flags: bit 0 read setup, bit 1 write hold, bit 2 write width |
| viol_event | output | 3 | One-cycle violation pulses, same bit layout |
| rd_setup_cnt | output | CNT_W | Read setup violation count |
| wr_hold_cnt | output | CNT_W | Write hold violation count |
| wr_width_cnt | output | CNT_W | Write width violation count |
| wr_good_cnt | output | CNT_W | Writes judged latched |
| wr_lost_cnt | output | CNT_W | Writes judged lost |
| wr_good_pulse | output | 1 | One-cycle pulse per good write |
| wr_lost_pulse | output | 1 | One-cycle pulse per lost write |

## Verification
On every cycle the assertions check several invariants. Flags never drop without a clear, and a clear empties every flag and counter. Each counter moves by at most one step at a time. A violation pulse always goes with its flag. A write never ends both good and lost, and it is never open and awaiting a verdict at once. Only the bench scenarios can show that intervals are measured correctly. That covers the exact boundaries at each limit, the same-cycle edge cases, the pipeline latency, edges ignored outside a frame, two writes in one frame, saturation, and a clear landing on the same cycle as an event. For this the bench compares the outputs every cycle against a behavioural model that keeps time stamps.

// File: rtl/strobe_mon_pkg.sv
package strobe_mon_pkg;

  localparam int NUM_RULES    = 3;
  localparam int RULE_RD_SU   = 0;
  localparam int RULE_WR_HOLD = 1;
  localparam int RULE_WR_WID  = 2;

  localparam int LINE_CS = 0;
  localparam int LINE_RD = 1;
  localparam int LINE_WR = 2;
  localparam int NUM_LINES = 3;

  typedef logic [NUM_RULES-1:0] rule_vec_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);

  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;
  logic [W-1:0]             prev_q;

  always_comb begin
    chain_d[0] = d_in;
    for (int s = 1; s < STAGES; s++) begin
      chain_d[s] = chain_q[s-1];
    end
  end

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '1;
        else        chain_q[s] <= chain_d[s];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign q      = chain_q[STAGES-1];
  assign q_prev = prev_q;

endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int MAX = 6,
  parameter int VW  = $clog2(MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [VW-1:0] value
);

  localparam logic [VW-1:0] MAXV = VW'(MAX);

  logic [VW-1:0] t_q, t_d;

  always_comb begin
    t_d = t_q;
    if (start)            t_d = VW'(1);
    else if (t_q != MAXV) t_d = t_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) t_q <= MAXV;
    else        t_q <= t_d;
  end

  assign value = t_q;

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] c_q, c_d;
  logic         c_en;

  always_comb begin
    c_en = clr | (inc & (c_q != TOP));
    c_d  = clr ? '0 : c_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    c_q <= '0;
    else if (c_en) c_q <= c_d;
  end

  assign count = c_q;

endmodule

// File: rtl/rule_tracker.sv
module rule_tracker #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hit,
  output logic             flag,
  output logic [CNT_W-1:0] count
);

  logic flag_q, flag_d;

  always_comb begin
    flag_d = clr ? 1'b0 : (flag_q | hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  sat_counter #(.W(CNT_W)) cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .inc   (hit),
    .count (count)
  );

  assign flag = flag_q;

endmodule

// File: rtl/strobe_timing_monitor.sv
module strobe_timing_monitor
  import strobe_mon_pkg::*;
#(
  parameter int RD_SETUP_CYC = 6,
  parameter int WR_HOLD_CYC  = 4,
  parameter int WR_WIDTH_CYC = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int CNT_W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cs_n_in,
  input  logic             rd_n_in,
  input  logic             wr_n_in,
  output logic [2:0]       viol_flag,
  output logic [2:0]       viol_event,
  output logic [CNT_W-1:0] rd_setup_cnt,
  output logic [CNT_W-1:0] wr_hold_cnt,
  output logic [CNT_W-1:0] wr_width_cnt,
  output logic [CNT_W-1:0] wr_good_cnt,
  output logic [CNT_W-1:0] wr_lost_cnt,
  output logic             wr_good_pulse,
  output logic             wr_lost_pulse
);

  localparam int TMAX = max3(RD_SETUP_CYC, WR_HOLD_CYC, WR_WIDTH_CYC);
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] RS_L = TW'(RD_SETUP_CYC);
  localparam logic [TW-1:0] WH_L = TW'(WR_HOLD_CYC);
  localparam logic [TW-1:0] WW_L = TW'(WR_WIDTH_CYC);

  // synchronized levels and edges
  logic [NUM_LINES-1:0] lvl, lvl_prev;
  logic cs_low, cs_fall, cs_rise, rd_fall, wr_fall, wr_rise;

  strobe_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_in   ({wr_n_in, rd_n_in, cs_n_in}),
    .q      (lvl),
    .q_prev (lvl_prev)
  );

  always_comb begin
    cs_low  = ~lvl[LINE_CS];
    cs_fall = lvl_prev[LINE_CS] & ~lvl[LINE_CS];
    cs_rise = ~lvl_prev[LINE_CS] & lvl[LINE_CS];
    rd_fall = lvl_prev[LINE_RD] & ~lvl[LINE_RD];
    wr_fall = lvl_prev[LINE_WR] & ~lvl[LINE_WR];
    wr_rise = ~lvl_prev[LINE_WR] & lvl[LINE_WR];
  end

  // write tracking state
  logic wr_open_q, wr_open_d;
  logic wr_pend_q, wr_pend_d;
  logic pend_bad_q, pend_bad_d;
  logic wr_start, wr_close;

  assign wr_start = cs_low & wr_fall;
  assign wr_close = wr_open_q & wr_rise;

  // interval timers
  logic [TW-1:0] t_cs, t_wr, t_wrr;

  interval_timer #(.MAX(TMAX), .VW(TW)) tmr_cs_i (
    .clk(clk), .rst_n(rst_n), .start(cs_fall), .value(t_cs));

  interval_timer #(.MAX(TMAX), .VW(TW)) tmr_wr_i (
    .clk(clk), .rst_n(rst_n), .start(wr_start), .value(t_wr));

  interval_timer #(.MAX(TMAX), .VW(TW)) tmr_wrr_i (
    .clk(clk), .rst_n(rst_n), .start(wr_close), .value(t_wrr));

  // rule evaluation
  logic [TW-1:0] rd_int, hold_int;
  logic          width_short, hold_short, pend_bad_eff, open_at_rise;
  logic          fin_frame, fin_frame_bad, fin_next;
  logic          good_d, lost_d;
  rule_vec_t     hit;

  always_comb begin
    rd_int       = cs_fall ? '0 : t_cs;
    hold_int     = wr_close ? '0 : t_wrr;
    width_short  = wr_close & (t_wr < WW_L);
    hold_short   = hold_int < WH_L;
    pend_bad_eff = wr_close ? width_short : pend_bad_q;
    open_at_rise = wr_open_q & ~wr_rise;

    hit               = '0;
    hit[RULE_RD_SU]   = cs_low & rd_fall & (rd_int < RS_L);
    hit[RULE_WR_WID]  = width_short;
    hit[RULE_WR_HOLD] = cs_rise &
                        (open_at_rise | ((wr_close | wr_pend_q) & hold_short));

    fin_frame     = cs_rise & (wr_open_q | wr_pend_q);
    fin_frame_bad = open_at_rise | pend_bad_eff | hold_short;
    fin_next      = wr_start & wr_pend_q;

    good_d = (fin_frame & ~fin_frame_bad) | (fin_next & ~pend_bad_q);
    lost_d = (fin_frame &  fin_frame_bad) | (fin_next &  pend_bad_q);
  end

  // next state of the write tracker
  always_comb begin
    wr_open_d  = wr_open_q;
    wr_pend_d  = wr_pend_q;
    pend_bad_d = pend_bad_q;
    if (wr_start)                 wr_open_d = 1'b1;
    else if (cs_rise | wr_close)  wr_open_d = 1'b0;
    if (cs_rise)                  wr_pend_d = 1'b0;
    else if (wr_close)            wr_pend_d = 1'b1;
    else if (wr_start)            wr_pend_d = 1'b0;
    if (wr_close)                 pend_bad_d = width_short;
  end

  // registers
  logic [2:0] event_q;
  logic       good_q, lost_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_open_q  <= 1'b0;
      wr_pend_q  <= 1'b0;
      pend_bad_q <= 1'b0;
      event_q    <= '0;
      good_q     <= 1'b0;
      lost_q     <= 1'b0;
    end else begin
      wr_open_q  <= wr_open_d;
      wr_pend_q  <= wr_pend_d;
      pend_bad_q <= pend_bad_d;
      event_q    <= hit;
      good_q     <= good_d;
      lost_q     <= lost_d;
    end
  end

  // per-rule sticky flags and counters
  logic [NUM_RULES-1:0][CNT_W-1:0] cnt_all;
  rule_vec_t                       flag_all;

  generate
    for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
      rule_tracker #(.CNT_W(CNT_W)) trk_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .hit   (hit[r]),
        .flag  (flag_all[r]),
        .count (cnt_all[r])
      );
    end
  endgenerate

  sat_counter #(.W(CNT_W)) good_cnt_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(good_d), .count(wr_good_cnt));

  sat_counter #(.W(CNT_W)) lost_cnt_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(lost_d), .count(wr_lost_cnt));

  assign viol_flag     = flag_all;
  assign viol_event    = event_q;
  assign rd_setup_cnt  = cnt_all[RULE_RD_SU];
  assign wr_hold_cnt   = cnt_all[RULE_WR_HOLD];
  assign wr_width_cnt  = cnt_all[RULE_WR_WID];
  assign wr_good_pulse = good_q;
  assign wr_lost_pulse = lost_q;

endmodule

// File: rtl/strobe_timing_monitor_chk.sv
module strobe_timing_monitor_chk
  import strobe_mon_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            clr,
  input logic [2:0]                      viol_flag,
  input logic [2:0]                      viol_event,
  input logic [NUM_RULES-1:0][CNT_W-1:0] cnt_all,
  input logic [CNT_W-1:0]                wr_good_cnt,
  input logic [CNT_W-1:0]                wr_lost_cnt,
  input logic                            wr_good_pulse,
  input logic                            wr_lost_pulse,
  input logic                            wr_open,
  input logic                            wr_pend
);

  generate
    for (genvar i = 0; i < NUM_RULES; i++) begin : g_rule
      // R8
      sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_flag[i] && !clr) |=> viol_flag[i]);

      // R2 R3 R4
      event_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_event[i] && !$past(clr)) |-> viol_flag[i]);

      // R9
      cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt_all[i] == $past(cnt_all[i]) ||
                  cnt_all[i] == $past(cnt_all[i]) + 1'b1));
    end
  endgenerate

  // R8
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (viol_flag == '0 && cnt_all == '0 &&
             wr_good_cnt == '0 && wr_lost_cnt == '0));

  // R7
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_good_pulse, wr_lost_pulse}));

  // R7
  good_counted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_good_pulse && !$past(clr)) |-> wr_good_cnt != '0);

  // R5
  open_pend_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_open && wr_pend));

endmodule

bind strobe_timing_monitor strobe_timing_monitor_chk #(.CNT_W(CNT_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .clr           (clr),
  .viol_flag     (viol_flag),
  .viol_event    (viol_event),
  .cnt_all       (cnt_all),
  .wr_good_cnt   (wr_good_cnt),
  .wr_lost_cnt   (wr_lost_cnt),
  .wr_good_pulse (wr_good_pulse),
  .wr_lost_pulse (wr_lost_pulse),
  .wr_open       (wr_open_q),
  .wr_pend       (wr_pend_q)
);

// File: tb/strobe_timing_monitor_tb_top.sv
`timescale 1ns/1ps
module strobe_timing_monitor_tb_top;

  localparam int RS   = 6;
  localparam int WH   = 4;
  localparam int WW   = 4;
  localparam int CW   = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, clr, cs_n, rd_n, wr_n;
  logic [2:0]    viol_flag, viol_event;
  logic [CW-1:0] rd_setup_cnt, wr_hold_cnt, wr_width_cnt, wr_good_cnt, wr_lost_cnt;
  logic          wr_good_pulse, wr_lost_pulse;

  strobe_timing_monitor #(
    .RD_SETUP_CYC(RS), .WR_HOLD_CYC(WH), .WR_WIDTH_CYC(WW),
    .SYNC_STAGES(2), .CNT_W(CW)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .cs_n_in(cs_n), .rd_n_in(rd_n), .wr_n_in(wr_n),
    .viol_flag(viol_flag), .viol_event(viol_event),
    .rd_setup_cnt(rd_setup_cnt), .wr_hold_cnt(wr_hold_cnt),
    .wr_width_cnt(wr_width_cnt), .wr_good_cnt(wr_good_cnt),
    .wr_lost_cnt(wr_lost_cnt), .wr_good_pulse(wr_good_pulse),
    .wr_lost_pulse(wr_lost_pulse)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  bit cmp_en = 1'b0;
  bit ev_seen = 1'b0;

  // behavioural reference model: time stamps of edges, integer counts
  bit m_cs1, m_cs2, m_csp, m_rd1, m_rd2, m_rdp, m_wr1, m_wr2, m_wrp;
  int cyc, ts_csf, ts_wrf, ts_wrr;
  bit m_open, m_pend, m_pbad;
  bit [2:0] m_flag, m_ev;
  int m_cnt[3];
  int m_good, m_lost;
  bit m_gp, m_lp;

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic model_reset();
    {m_cs1, m_cs2, m_csp, m_rd1, m_rd2, m_rdp, m_wr1, m_wr2, m_wrp} = '1;
    cyc = 0; ts_csf = 0; ts_wrf = 0; ts_wrr = 0;
    m_open = 0; m_pend = 0; m_pbad = 0;
    m_flag = '0; m_ev = '0;
    for (int i = 0; i < 3; i++) m_cnt[i] = 0;
    m_good = 0; m_lost = 0; m_gp = 0; m_lp = 0;
  endtask

  task automatic model_step();
    bit csf, csr, rdf, wrf, wrr, g, l, shrt;
    bit [2:0] e;
    int iv;
    csf = m_csp & ~m_cs2;  csr = ~m_csp & m_cs2;
    rdf = m_rdp & ~m_rd2;
    wrf = m_wrp & ~m_wr2;  wrr = ~m_wrp & m_wr2;
    e = '0; g = 0; l = 0;
    if (!m_cs2 && rdf) begin
      iv = csf ? 0 : cyc - ts_csf;
      if (iv < RS) e[0] = 1;
    end
    if (csf) ts_csf = cyc;
    if (m_open && wrr) begin
      iv = cyc - ts_wrf;
      shrt = (iv < WW);
      if (shrt) e[2] = 1;
      m_open = 0; m_pend = 1; m_pbad = shrt; ts_wrr = cyc;
    end
    if (!m_cs2 && wrf) begin
      if (m_pend) begin
        if (m_pbad) l = 1; else g = 1;
        m_pend = 0;
      end
      m_open = 1; ts_wrf = cyc;
    end
    if (csr) begin
      if (m_open) begin
        e[1] = 1; l = 1; m_open = 0;
      end else if (m_pend) begin
        iv = cyc - ts_wrr;
        if (iv < WH) begin e[1] = 1; m_pbad = 1; end
        if (m_pbad) l = 1; else g = 1;
        m_pend = 0;
      end
    end
    if (clr) begin
      m_flag = '0;
      for (int i = 0; i < 3; i++) m_cnt[i] = 0;
      m_good = 0; m_lost = 0;
    end else begin
      m_flag = m_flag | e;
      for (int i = 0; i < 3; i++) m_cnt[i] = sat(m_cnt[i] + int'(e[i]));
      m_good = sat(m_good + int'(g));
      m_lost = sat(m_lost + int'(l));
    end
    m_ev = e; m_gp = g; m_lp = l;
    m_csp = m_cs2; m_cs2 = m_cs1; m_cs1 = cs_n;
    m_rdp = m_rd2; m_rd2 = m_rd1; m_rd1 = rd_n;
    m_wrp = m_wr2; m_wr2 = m_wr1; m_wr1 = wr_n;
    cyc++;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else        model_step();
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      check("R8 sticky flags",        int'(viol_flag), int'(m_flag));
      check("R2 read setup event",    int'(viol_event[0]), int'(m_ev[0]));
      check("R4 write hold event",    int'(viol_event[1]), int'(m_ev[1]));
      check("R3 write width event",   int'(viol_event[2]), int'(m_ev[2]));
      check("R9 read setup count",    int'(rd_setup_cnt), m_cnt[0]);
      check("R9 write hold count",    int'(wr_hold_cnt),  m_cnt[1]);
      check("R9 write width count",   int'(wr_width_cnt), m_cnt[2]);
      check("R7 good write count",    int'(wr_good_cnt),  m_good);
      check("R7 lost write count",    int'(wr_lost_cnt),  m_lost);
      check("R7 good write pulse",    int'(wr_good_pulse), int'(m_gp));
      check("R7 lost write pulse",    int'(wr_lost_pulse), int'(m_lp));
      if (viol_event != '0 || wr_good_pulse || wr_lost_pulse) ev_seen = 1'b1;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    clr = 1'b1; tick(1); clr = 1'b0;
  endtask

  task automatic wr_acc(input int su, input int w, input int h);
    cs_n = 1'b0; tick(su);
    wr_n = 1'b0; tick(w);
    wr_n = 1'b1; tick(h);
    cs_n = 1'b1; tick(10);
  endtask

  task automatic rd_acc(input int su);
    cs_n = 1'b0; tick(su);
    rd_n = 1'b0; tick(3);
    rd_n = 1'b1; tick(2);
    cs_n = 1'b1; tick(8);
  endtask

  task automatic expect_state(input string tag, input int fl, input int rsc,
                              input int hc, input int wc, input int gc, input int lc);
    check({tag, " flags"},       int'(viol_flag),    fl);
    check({tag, " rd setup cnt"}, int'(rd_setup_cnt), rsc);
    check({tag, " hold cnt"},    int'(wr_hold_cnt),  hc);
    check({tag, " width cnt"},   int'(wr_width_cnt), wc);
    check({tag, " good cnt"},    int'(wr_good_cnt),  gc);
    check({tag, " lost cnt"},    int'(wr_lost_cnt),  lc);
  endtask

  task automatic report();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    tick(4);
    // R1 reset state
    expect_state("R1 reset", 0, 0, 0, 0, 0, 0);
    check("R1 reset events", int'(viol_event), 0);
    check("R1 reset pulses", int'({wr_good_pulse, wr_lost_pulse}), 0);
    rst_n = 1'b1; cmp_en = 1'b1;
    tick(4);

    // R7 clean write at the exact limits of R3 and R4
    pulse_clr(); wr_acc(RS, WW, WH);
    expect_state("R7 clean write", 0, 0, 0, 0, 1, 0);

    // R3 pulse one cycle short
    pulse_clr(); wr_acc(RS, WW - 1, WH);
    expect_state("R3 short pulse", 4, 0, 0, 1, 0, 1);

    // R4 hold one cycle short
    pulse_clr(); wr_acc(RS, WW, WH - 1);
    expect_state("R4 short hold", 2, 0, 1, 0, 0, 1);

    // R4 write and chip-select released together
    pulse_clr(); wr_acc(RS, WW, 0);
    expect_state("R4 zero hold", 2, 0, 1, 0, 0, 1);

    // R5 chip-select released while write still low
    pulse_clr();
    cs_n = 1'b0; tick(RS); wr_n = 1'b0; tick(5);
    cs_n = 1'b1; tick(3); wr_n = 1'b1; tick(10);
    expect_state("R5 open at release", 2, 0, 1, 0, 0, 1);

    // R2 boundaries: exact limit, one short, same cycle
    pulse_clr(); rd_acc(RS);
    expect_state("R2 setup at limit", 0, 0, 0, 0, 0, 0);
    rd_acc(RS - 1);
    expect_state("R2 setup short", 1, 1, 0, 0, 0, 0);
    rd_acc(0);
    expect_state("R2 setup zero", 1, 2, 0, 0, 0, 0);

    // R1 latency: event visible after the third rising edge
    pulse_clr();
    cs_n = 1'b0; tick(2); rd_n = 1'b0;
    tick(1); check("R1 latency edge1", int'(viol_event[0]), 0);
    tick(1); check("R1 latency edge2", int'(viol_event[0]), 0);
    tick(1); check("R1 latency edge3", int'(viol_event[0]), 1);
    tick(2); rd_n = 1'b1; tick(2); cs_n = 1'b1; tick(8);

    // R6 strobe activity outside a frame
    pulse_clr(); ev_seen = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      wr_n = 1'b0; tick(k); rd_n = 1'b0; tick(1);
      wr_n = 1'b1; tick(2); rd_n = 1'b1; tick(k);
    end
    tick(6);
    expect_state("R6 ignored", 0, 0, 0, 0, 0, 0);
    check("R6 no pulses", int'(ev_seen), 0);

    // R7 two writes in one frame: first short, second clean
    pulse_clr();
    cs_n = 1'b0; tick(RS);
    wr_n = 1'b0; tick(2); wr_n = 1'b1; tick(2);
    wr_n = 1'b0; tick(WW); wr_n = 1'b1; tick(WH);
    cs_n = 1'b1; tick(10);
    expect_state("R7 two writes", 4, 0, 0, 1, 1, 1);

    // R7 two clean writes, short gap between them
    pulse_clr();
    cs_n = 1'b0; tick(RS);
    wr_n = 1'b0; tick(WW); wr_n = 1'b1; tick(1);
    wr_n = 1'b0; tick(WW); wr_n = 1'b1; tick(WH);
    cs_n = 1'b1; tick(10);
    expect_state("R7 back to back", 0, 0, 0, 0, 2, 0);

    // R9 saturation
    pulse_clr();
    for (int k = 0; k < CMAX + 3; k++) rd_acc(1);
    expect_state("R9 saturated", 1, CMAX, 0, 0, 0, 0);

    // R8 clear landing at every offset of a bad write
    for (int off = 0; off < 20; off++) begin
      fork
        wr_acc(RS, WW - 2, WH - 2);
        begin tick(off); clr = 1'b1; tick(1); clr = 1'b0; end
      join
    end
    pulse_clr();
    expect_state("R8 cleared", 0, 0, 0, 0, 0, 0);

    tick(4);
    report();
  end

endmodule